// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block forms the full-width product of two signed two's-complement operands of `N` bits each, one multiplier bit per clock cycle. It keeps the upper partial product and the multiplier together in one combined register, extended by one bit on the right. Each cycle it inspects the lowest multiplier bit together with the bit that was shifted out just before it. From that pair it either adds the multiplicand into the upper half, subtracts it, or leaves the upper half alone. Then the whole combined register takes an arithmetic right shift. Negative operands need no sign conversion, because the recoding handles two's complement directly.

To use it, a client pulses `start` with both operands present. It then waits for the one-cycle `done` pulse and reads the product as a high half and a low half. A flag reports whether the product would survive being truncated to the low half as a signed value. A single `N+1`-bit adder/subtractor is shared by all iterations.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset `busy`, `done`, `fits_err`, `prod_hi` and `prod_lo` are all 0.
- R2: A `start` seen at a clock edge while `busy` is low is accepted: `busy` is 1 from the next cycle and stays 1 for exactly `N` cycles.
- R3: `done` is 1 for exactly one cycle, the cycle right after the last busy cycle, and `busy` is 0 while `done` is 1.
- R4: While `done` is 1, `{prod_hi, prod_lo}` equals the signed `2N`-bit product of the operands captured at the accepted start, with `prod_hi` the upper `N` bits.
- R5: With `N = 4`, multiplicand 4'b0010 and multiplier 4'b1101 (2 times -3) give `prod_hi` = 4'b1111 and `prod_lo` = 4'b1010.
- R6: The most negative operand is handled: for `N = 8`, -128 times -128 gives 16'h4000, -128 times -1 gives 16'h0080, and -128 times 127 gives 16'hC080.
- R7: While `done` is 1, `fits_err` is 1 exactly when `prod_hi` differs from `N` copies of `prod_lo[N-1]`.
- R8: A `start` that arrives while `busy` is 1 is ignored. The run in progress keeps its length and its result, and the new operands are not used.
- R9: While the block is idle and no `start` is given, `prod_hi`, `prod_lo` and `fits_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply; accepted only while idle |
| mcand | input | N | Multiplicand, signed |
| mplier | input | N | Multiplier, signed |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse, result valid |
| prod_hi | output | N | Upper half of the signed product |
| prod_lo | output | N | Lower half of the signed product |
| fits_err | output | 1 | Product does not fit in `prod_lo` as a signed value |

## Verification
The bench builds two instances side by side. The first uses `N = 8` and runs a table of hand-worked products, including the most negative operand against itself, against -1 and against 127, plus a start issued in mid-run. The second uses `N = 4`, which is small enough to sweep every operand pair. That sweep covers every recoding pattern, every guard-bit overflow of the shared adder, and every case of the fit flag.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    // Radix-2 recoding of the current multiplier bit and the bit shifted out before it
    function automatic booth_op_e booth_decode(input logic cur, input logic prev);
        case ({cur, prev})
            2'b10:   return OP_SUB;
            2'b01:   return OP_ADD;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);
    always_comb op = booth_decode(cur_bit, prev_bit);
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] addend,
    input  booth_op_e    op,
    output logic [W:0]   sum
);
    logic [W:0] acc_x;
    logic [W:0] add_x;

    // One guard bit keeps the exact sign of add or subtract results
    always_comb begin
        acc_x = {acc[W-1], acc};
        add_x = {addend[W-1], addend};
        case (op)
            OP_ADD:  sum = acc_x + add_x;
            OP_SUB:  sum = acc_x - add_x;
            default: sum = acc_x;
        endcase
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic last
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] iter_q;

    assign load = start && !busy;
    assign last = busy && (iter_q == CW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            iter_q <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy   <= 1'b1;
                iter_q <= '0;
            end else if (busy) begin
                iter_q <= iter_q + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] mcand,
    input  logic [N-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] prod_hi,
    output logic [N-1:0] prod_lo,
    output logic         fits_err
);
    logic [N-1:0] hi_q;
    logic [N-1:0] lo_q;
    logic         ext_q;
    logic [N-1:0] mc_q;
    logic         wide_q;

    logic         load;
    logic         last;
    booth_op_e    op;
    logic [N:0]   sum;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .last  (last)
    );

    booth_recode u_recode (
        .cur_bit  (lo_q[0]),
        .prev_bit (ext_q),
        .op       (op)
    );

    booth_addsub #(.W(N)) u_addsub (
        .acc    (hi_q),
        .addend (mc_q),
        .op     (op),
        .sum    (sum)
    );

    // Combined register {hi, lo, ext}: add/sub into hi, then arithmetic shift right
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            ext_q  <= 1'b0;
            mc_q   <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            hi_q   <= '0;
            lo_q   <= mplier;
            ext_q  <= 1'b0;
            mc_q   <= mcand;
            wide_q <= 1'b0;
        end else if (busy) begin
            hi_q  <= sum[N:1];
            lo_q  <= {sum[0], lo_q[N-1:1]};
            ext_q <= lo_q[0];
            if (last)
                wide_q <= (sum[N:1] != {N{sum[0]}});
        end
    end

    assign prod_hi  = hi_q;
    assign prod_lo  = lo_q;
    assign fits_err = wide_q;
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [N-1:0] mcand,
    input logic [N-1:0] mplier,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] prod_hi,
    input logic [N-1:0] prod_lo,
    input logic         fits_err
);
    localparam int CW = $clog2(N + 1) + 1;

    logic [CW-1:0]  run_cnt;
    logic [N-1:0]   cap_a;
    logic [N-1:0]   cap_b;
    logic [2*N-1:0] ext_a;
    logic [2*N-1:0] ext_b;
    logic [2*N-1:0] ref_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            cap_a   <= mcand;
            cap_b   <= mplier;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign ext_a = {{N{cap_a[N-1]}}, cap_a};
    assign ext_b = {{N{cap_b[N-1]}}, cap_b};
    assign ref_p = ext_a * ext_b;

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == CW'(N)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R4
    product_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ({prod_hi, prod_lo} == ref_p));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (fits_err == (prod_hi != {N{prod_lo[N-1]}})));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo) && $stable(fits_err)));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mcand    (mcand),
    .mplier   (mplier),
    .busy     (busy),
    .done     (done),
    .prod_hi  (prod_hi),
    .prod_lo  (prod_lo),
    .fits_err (fits_err)
);

// File: tb/booth_seq_mul_tb.sv
module booth_seq_mul_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // N = 8 instance
    logic       st8 = 1'b0;
    logic [7:0] a8 = '0, b8 = '0, hi8, lo8;
    logic       busy8, done8, wide8;

    booth_seq_mul #(.N(8)) u_dut (
        .clk(clk), .rst(rst), .start(st8), .mcand(a8), .mplier(b8),
        .busy(busy8), .done(done8), .prod_hi(hi8), .prod_lo(lo8), .fits_err(wide8)
    );

    // N = 4 instance
    logic       st4 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0, hi4, lo4;
    logic       busy4, done4, wide4;

    booth_seq_mul #(.N(4)) u_dut4 (
        .clk(clk), .rst(rst), .start(st4), .mcand(a4), .mplier(b4),
        .busy(busy4), .done(done4), .prod_hi(hi4), .prod_lo(lo4), .fits_err(wide4)
    );

    // {mcand, mplier, expected product, expected fit flag}
    localparam logic [32:0] VEC [12] = '{
        {8'h03, 8'h05, 16'h000F, 1'b0},
        {8'hFD, 8'h05, 16'hFFF1, 1'b0},
        {8'h07, 8'hF7, 16'hFFC1, 1'b0},
        {8'hF4, 8'hF5, 16'h0084, 1'b1},
        {8'h7F, 8'h7F, 16'h3F01, 1'b1},
        {8'h80, 8'h80, 16'h4000, 1'b1},
        {8'h80, 8'hFF, 16'h0080, 1'b1},
        {8'h80, 8'h7F, 16'hC080, 1'b1},
        {8'h00, 8'hB3, 16'h0000, 1'b0},
        {8'hFF, 8'hFF, 16'h0001, 1'b0},
        {8'h55, 8'hAA, 16'hE372, 1'b1},
        {8'h10, 8'hF8, 16'hFF80, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string detail);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    // One N=8 run; optionally a second start mid-run with other operands
    task automatic run8(input logic [7:0] a, input logic [7:0] b, input bit inject,
                        output logic [15:0] p, output logic w);
        int cnt;
        logic [15:0] held;
        @(negedge clk);
        a8 = a; b8 = b; st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0;
        check(busy8 == 1'b1, "R2", $sformatf("busy act=%0b exp=1", busy8));
        cnt = 0;
        while (busy8 && cnt < 40) begin
            cnt++;
            if (inject && cnt == 3) begin
                a8 = 8'h33; b8 = 8'h44; st8 = 1'b1;
            end else begin
                st8 = 1'b0;
            end
            @(negedge clk);
        end
        st8 = 1'b0;
        check(cnt == 8, inject ? "R8" : "R2", $sformatf("busy cycles act=%0d exp=8", cnt));
        check(done8 == 1'b1, "R3", $sformatf("done act=%0b exp=1", done8));
        p = {hi8, lo8};
        w = wide8;
        held = {hi8, lo8};
        @(negedge clk);
        check(done8 == 1'b0, "R3", $sformatf("done second cycle act=%0b exp=0", done8));
        check({hi8, lo8} == held && wide8 == w, "R9",
              $sformatf("held act=%h exp=%h", {hi8, lo8}, held));
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b,
                        output logic [7:0] p, output logic w);
        int cnt;
        @(negedge clk);
        a4 = a; b4 = b; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        cnt = 0;
        while (busy4 && cnt < 20) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == 4 && done4, "R2", $sformatf("n4 busy cycles act=%0d exp=4", cnt));
        p = {hi4, lo4};
        w = wide4;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] p16;
        logic        w;
        logic [7:0]  p8;
        int          e;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!busy8 && !done8 && !wide8 && hi8 == 0 && lo8 == 0, "R1",
              $sformatf("reset act=%b%b%b %h exp=000 0000", busy8, done8, wide8, {hi8, lo8}));

        // R4 R6 R7: vector table
        for (int i = 0; i < 12; i++) begin
            run8(VEC[i][32:25], VEC[i][24:17], 1'b0, p16, w);
            check(p16 == VEC[i][16:1], "R4",
                  $sformatf("%h*%h act=%h exp=%h", VEC[i][32:25], VEC[i][24:17], p16, VEC[i][16:1]));
            check(w == VEC[i][0], "R7",
                  $sformatf("%h*%h flag act=%0b exp=%0b", VEC[i][32:25], VEC[i][24:17], w, VEC[i][0]));
        end

        // R6: most negative operand corners named directly
        run8(8'h80, 8'h80, 1'b0, p16, w);
        check(p16 == 16'h4000, "R6", $sformatf("-128*-128 act=%h exp=4000", p16));
        run8(8'h80, 8'hFF, 1'b0, p16, w);
        check(p16 == 16'h0080, "R6", $sformatf("-128*-1 act=%h exp=0080", p16));

        // R8: start while busy ignored
        run8(8'hF9, 8'h0B, 1'b1, p16, w);
        check(p16 == 16'hFFB3, "R8", $sformatf("-7*11 with mid-run start act=%h exp=ffb3", p16));
        repeat (3) @(negedge clk);
        check(!busy8 && {hi8, lo8} == 16'hFFB3, "R8",
              $sformatf("after ignored start act=%0b %h exp=0 ffb3", busy8, {hi8, lo8}));

        // R5: 4-bit worked case
        run4(4'b0010, 4'b1101, p8, w);
        check(p8 == 8'b1111_1010, "R5", $sformatf("2*-3 act=%b exp=11111010", p8));

        // R4 R7: exhaustive N=4 sweep
        for (int x = -8; x < 8; x++) begin
            for (int y = -8; y < 8; y++) begin
                run4(4'(x), 4'(y), p8, w);
                e = x * y;
                check(p8 == 8'(e), "R4", $sformatf("n4 %0d*%0d act=%h exp=%h", x, y, p8, 8'(e)));
                check(w == (e < -8 || e > 7), "R7",
                      $sformatf("n4 %0d*%0d flag act=%0b exp=%0b", x, y, w, (e < -8 || e > 7)));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule